// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Control Registers

This block sits behind a serial receiver and in front of four converter channels. It accepts one 16-bit command word per `cmd_valid` cycle. The word carries a channel address, a power-down flag, a speed flag and an 8-bit code. Each channel keeps its code and flags twice. The first copy is a holding stage that every addressed write fills. The second copy is an output stage that drives the converter.

An active-low load strobe controls when the output stage follows the holding stage. Software can hold the strobe high while it writes several channels, then drop it once so that all four channels change in the same cycle. With the strobe tied low, each write reaches the output stage directly.

An active-low global power-down input switches every channel's enable off without touching any stored code or flag. Releasing it brings each channel back with the settings it had before.

Top module: `quad_dbuf_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, all codes are 0, all per-channel power-down flags are 0 and all speed flags are 0 (slow). `ch_en` is therefore all ones whenever `pwrdn_n` is high.
- R2: Word bits 15:14 select the channel: 0 selects A (index 0), 1 selects B, 2 selects C and 3 selects D. A write changes no other channel's holding stage.
- R3: Word bits 11:4 are the code written to the addressed channel. Channel i appears on `ch_code[8*i+7:8*i]`.
- R4: Word bit 13 set to 1 powers the addressed channel down, which drives `ch_en[i]` to 0. Bit 13 set to 0 makes the channel active.
- R5: Word bit 12 set to 1 selects fast settling, shown as `ch_fast[i]` = 1. Bit 12 set to 0 selects slow settling.
- R6: A write taken at a clock edge where `load_n` is low appears on the outputs one cycle later.
- R7: At an edge where `load_n` is high, the output stage does not change. At an edge where `load_n` is low, every channel's output stage takes its holding value in the same cycle.
- R8: While `pwrdn_n` is low, `ch_en` is 0 for all channels, with no clock delay. When `pwrdn_n` goes high again, each channel's enable returns to what its own flag gives, and no code changes.
- R9: Word bits 3:0 are ignored. A word with nonzero low bits acts exactly like the same word with those bits cleared.
- R10: The power-down and speed flags reach `ch_en` and `ch_fast` only on the edge that loads that channel's output stage, the same as the code does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | The command word is valid in this cycle |
| cmd_word | input | 16 | Command word: address, power-down flag, speed flag, code |
| load_n | input | 1 | Load strobe, active low: the output stage follows the holding stage |
| pwrdn_n | input | 1 | Global power-down, active low |
| ch_code | output | 32 | Output-stage codes of the four channels, channel i at bits 8i+7:8i |
| ch_en | output | 4 | Effective enable of each channel |
| ch_fast | output | 4 | Speed selection of each channel (1 = fast) |

## Verification
Codes and flags are registered, so a write, a strobe or a reset release shows on `ch_code` and `ch_fast` one clock edge after it is taken. `ch_en` also depends combinationally on `pwrdn_n`, so a global power-down shows at once. The bench changes inputs on the falling edge. It samples outputs on the next falling edge, which comes after exactly one rising edge, so every vector's expected values describe the state after that one edge with the vector's own `pwrdn_n` applied. The hold-then-load sequence checks on the vectors where the strobe stays high that the outputs do not move. It then checks that every channel changes on the single cycle where the strobe goes low.

// File: rtl/quad_dbuf_ctrl.sv
module quad_dbuf_ctrl #(
  parameter int NCH    = 4,
  parameter int CODE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [WORD_W-1:0]     cmd_word,
  input  logic                  load_n,
  input  logic                  pwrdn_n,
  output logic [NCH*CODE_W-1:0] ch_code,
  output logic [NCH-1:0]        ch_en,
  output logic [NCH-1:0]        ch_fast
);
  localparam int ADDR_W   = $clog2(NCH);
  localparam int ADDR_LSB = WORD_W - ADDR_W;
  localparam int PD_BIT   = ADDR_LSB - 1;
  localparam int SPD_BIT  = PD_BIT - 1;
  localparam int CODE_LSB = SPD_BIT - CODE_W;

  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] wr_code;
  logic              unused_low;
  logic [CODE_W-1:0] hold_code [NCH];
  logic [CODE_W-1:0] out_code  [NCH];
  logic [NCH-1:0]    hold_pd, hold_spd, out_pd, out_spd;

  assign addr       = cmd_word[WORD_W-1 -: ADDR_W];
  assign wr_code    = cmd_word[CODE_LSB +: CODE_W];
  assign unused_low = ^cmd_word[CODE_LSB-1:0];

  assign ch_en   = {NCH{pwrdn_n}} & ~out_pd;
  assign ch_fast = out_spd;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic              sel;
    logic [CODE_W-1:0] nxt_code;
    logic              nxt_pd, nxt_spd;

    assign sel      = cmd_valid && (addr == ADDR_W'(i));
    assign nxt_code = sel ? wr_code           : hold_code[i];
    assign nxt_pd   = sel ? cmd_word[PD_BIT]  : hold_pd[i];
    assign nxt_spd  = sel ? cmd_word[SPD_BIT] : hold_spd[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_code[i] <= '0;
        hold_pd[i]   <= 1'b0;
        hold_spd[i]  <= 1'b0;
        out_code[i]  <= '0;
        out_pd[i]    <= 1'b0;
        out_spd[i]   <= 1'b0;
      end else begin
        if (sel) begin
          hold_code[i] <= nxt_code;
          hold_pd[i]   <= nxt_pd;
          hold_spd[i]  <= nxt_spd;
        end
        if (!load_n) begin
          out_code[i] <= nxt_code;
          out_pd[i]   <= nxt_pd;
          out_spd[i]  <= nxt_spd;
        end
      end
    end

    assign ch_code[i*CODE_W +: CODE_W] = out_code[i];

    // R6: a write under a low strobe reaches the addressed output one edge later
    p_direct_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && cmd_valid && cmd_word[WORD_W-1 -: ADDR_W] == ADDR_W'(i))
      |=> (ch_code[i*CODE_W +: CODE_W] == $past(cmd_word[CODE_LSB +: CODE_W])
           && ch_fast[i] == $past(cmd_word[SPD_BIT])));

    // R7, R10: a high strobe freezes code and flags
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_n |=> ($stable(ch_code[i*CODE_W +: CODE_W]) && $stable(ch_fast[i])
                  && $stable(out_pd[i])));

    // R7: an unaddressed channel copies its holding value when the strobe is low
    p_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && !(cmd_valid && cmd_word[WORD_W-1 -: ADDR_W] == ADDR_W'(i)))
      |=> ch_code[i*CODE_W +: CODE_W] == $past(hold_code[i]));

    // R2: a write addressed elsewhere leaves this holding stage alone
    p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_word[WORD_W-1 -: ADDR_W] != ADDR_W'(i))
      |=> $stable(hold_code[i]));
  end

  // R8: the global power-down turns every channel off
  p_global_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |-> ch_en == '0);

  // R8: releasing the global power-down leaves the codes untouched
  p_release_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwrdn_n) && $past(load_n)) |-> $stable(ch_code));
endmodule

// File: tb/quad_dbuf_ctrl_tb.sv
module quad_dbuf_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        load_n = 1'b1;
  logic        pwrdn_n = 1'b1;
  logic [31:0] ch_code;
  logic [3:0]  ch_en, ch_fast;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  quad_dbuf_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .load_n(load_n), .pwrdn_n(pwrdn_n),
    .ch_code(ch_code), .ch_en(ch_en), .ch_fast(ch_fast)
  );

  // {valid, load_n, pwrdn_n, word[15:0], exp_code[31:0], exp_en[3:0], exp_fast[3:0]}
  localparam int NV = 11;
  localparam logic [58:0] VEC [NV] = '{
    {3'b101, 16'h15A0, 32'h0000005A, 4'b1111, 4'b0001},
    {3'b111, 16'h6C30, 32'h0000005A, 4'b1111, 4'b0001},
    {3'b111, 16'hD810, 32'h0000005A, 4'b1111, 4'b0001},
    {3'b001, 16'h0000, 32'h8100C35A, 4'b1101, 4'b1001},
    {3'b100, 16'h87EF, 32'h817EC35A, 4'b0000, 4'b1001},
    {3'b011, 16'h0000, 32'h817EC35A, 4'b1101, 4'b1001},
    {3'b101, 16'h5FF0, 32'h817EFF5A, 4'b1111, 4'b1011},
    {3'b101, 16'h2000, 32'h817EFF00, 4'b1110, 4'b1010},
    {3'b111, 16'hB110, 32'h817EFF00, 4'b1110, 4'b1010},
    {3'b111, 16'hC220, 32'h817EFF00, 4'b1110, 4'b1010},
    {3'b101, 16'h0330, 32'h2211FF33, 4'b1011, 4'b0110}
  };

  function automatic string tag_of(int k);
    case (k)
      0: return "R3 R5 R6 chA direct";
      1: return "R7 R10 chB held";
      2: return "R7 R10 chD held";
      3: return "R7 R4 simultaneous load";
      4: return "R8 R9 global off, low bits ignored";
      5: return "R8 release restores";
      6: return "R2 R5 chB rewrite";
      7: return "R4 chA powered down";
      8: return "R10 flags held";
      9: return "R10 second held write";
      default: return "R7 R2 all channels at once";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset code", ch_code, 32'h0);
    check("R1 reset en", {28'h0, ch_en}, 32'hF);
    check("R1 reset fast", {28'h0, ch_fast}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release code", ch_code, 32'h0);

    for (int k = 0; k < NV; k++) begin
      {cmd_valid, load_n, pwrdn_n, cmd_word} = VEC[k][58:40];
      @(negedge clk);
      check({tag_of(k), " code"}, ch_code, VEC[k][39:8]);
      check({tag_of(k), " en"}, {28'h0, ch_en}, {28'h0, VEC[k][7:4]});
      check({tag_of(k), " fast"}, {28'h0, ch_fast}, {28'h0, VEC[k][3:0]});
    end

    // R8: global power-down is combinational
    cmd_valid = 1'b0; load_n = 1'b1;
    @(negedge clk);
    pwrdn_n = 1'b0;
    #1;
    check("R8 immediate off", {28'h0, ch_en}, 32'h0);
    check("R8 codes kept", ch_code, 32'h2211FF33);
    pwrdn_n = 1'b1;
    #1;
    check("R8 release en", {28'h0, ch_en}, 32'hB);

    // R1: reset mid-run clears everything, including the holding stage
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 midrun code", ch_code, 32'h0);
    check("R1 midrun en", {28'h0, ch_en}, 32'hF);
    check("R1 midrun fast", {28'h0, ch_fast}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    load_n = 1'b0;
    @(negedge clk);
    check("R1 holding cleared", ch_code, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule